// File: doc/BRIEF.md
# Instruction dispatch classifier

This block sits between register renaming and the scheduling structures of an out-of-order core. Each cycle it may receive one group of up to `W` renamed instructions, each described by six class flags. It walks the slots from slot 0 upward, sorts each instruction by class, and raises write strobes toward the issue queue, the load/store queue and a separate list that holds non-speculative work. It also returns per-slot status marks (issued, executed, may-commit) and a tail-advance strobe for instructions that take no scheduling entry.

The issue queue is outside the block and is seen only through its current free-entry count. Each slot that needs a scheduling entry uses one of them. When a slot that is not squashed finds no entry left, the walk stops there. The remaining slots of the group are dropped for this cycle, and a block request goes out. The input is qualified by `in_valid` alone, and the group is always consumed in the cycle it is presented. Back-pressure is carried only by `block_req`: while it is high, the upstream stage must hold or replay the unprocessed slots. Six wrapping event counters record what was dispatched and why.

All outputs are registered. A group presented before a rising edge shows its strobes, marks and counter updates right after that edge.

Top module: `dispatch_classifier`

## Requirements
- R1: Only slots with an index below `in_count` are examined, in ascending order, and only while `in_valid` is high. A cycle with `in_valid` low produces no strobe, no mark and no counter change.
- R2: A slot whose squashed flag (bit 0 of its 6-bit flag field) is set is skipped before any other check. It is counted in `cnt_sqsh`, takes no issue-queue entry and raises no strobe.
- R3: If a slot that is not squashed is reached while no issue-queue entry remains, `block_req` is raised and `cnt_full` is incremented. That slot and every later slot of the group raise nothing.
- R4: A load (bit 1) raises both `lsq_we` and `iq_we` for its slot and uses one entry. A store (bit 2) does the same. If a slot has both bits set, it is treated as a load.
- R5: A non-speculative slot (bit 3) raises only `nsl_we` and the may-commit mark. It takes no issue-queue entry.
- R6: A nop (bit 4) raises `tail_adv` and the issued, executed and may-commit marks. It takes no issue-queue entry.
- R7: A slot already flagged executed (bit 5), with none of bits 0 to 4 set, raises `exec_err` and is otherwise handled exactly as a nop.
- R8: `cnt_disp` counts `iq_we` strobes, `cnt_load` and `cnt_store` count memory-queue insertions by class, `cnt_nspec` counts `nsl_we` strobes, and `cnt_full` counts block requests.
- R9: After reset, all strobes, marks, `block_req` and all counters are zero. Results appear one clock edge after the group is presented.
- R10: A slot with no class flag set raises `iq_we` only and uses one issue-queue entry, so `iq_free` entries allow at most that many `iq_we` strobes per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group present this cycle |
| in_count | input | CNTW | Number of occupied slots, 0..W |
| in_flags | input | 6*W | Per-slot flags, slot i at bits [6i+5:6i]: squashed, load, store, non-speculative, nop, executed (bit 0 upward) |
| iq_free | input | FW | Free issue-queue entries this cycle |
| iq_we | output | W | Issue-queue insert strobe per slot |
| lsq_we | output | W | Load/store-queue reserve strobe per slot |
| nsl_we | output | W | Non-speculative list insert strobe per slot |
| tail_adv | output | W | Issue-queue tail advance without an entry |
| mark_issued | output | W | Issued mark per slot |
| mark_executed | output | W | Executed mark per slot |
| mark_commit | output | W | May-commit mark per slot |
| exec_err | output | W | Slot arrived already executed |
| block_req | output | 1 | Issue queue was full; request block and stall upstream |
| cnt_disp | output | CW | Issue-queue insertions |
| cnt_sqsh | output | CW | Squashed slots skipped |
| cnt_load | output | CW | Loads placed in the memory queue |
| cnt_store | output | CW | Stores placed in the memory queue |
| cnt_nspec | output | CW | Non-speculative insertions |
| cnt_full | output | CW | Queue-full events |

## Verification
Every cycle, the assertions check that each slot goes to at most one destination among the issue queue, the non-speculative list and the tail advance. They also check that every memory-queue strobe comes with an issue-queue strobe, that an error mark is always paired with a tail advance, and that no output moves after a cycle without a group. Two counter assertions tie `cnt_disp` and `cnt_full` to the strobes and block requests of each cycle. Only the bench's scenarios can show that the walk stops at the correct slot for a given free count, that a squashed slot beyond the free limit is still skipped rather than blocking, and that class priority and the count limit select the expected slots.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  // bit 0 upward: squashed, load, store, non-speculative, nop, executed
  typedef struct packed {
    logic exe;
    logic nop;
    logic nspec;
    logic st;
    logic ld;
    logic sq;
  } slot_flags_t;

  typedef enum logic [2:0] {
    K_SQ, K_LD, K_ST, K_NS, K_NOP, K_EXE, K_NORM
  } slot_kind_t;

  localparam int FLW  = $bits(slot_flags_t);
  localparam int NCNT = 6;
  // counter indices
  localparam int C_DISP = 0;
  localparam int C_SQSH = 1;
  localparam int C_LOAD = 2;
  localparam int C_STOR = 3;
  localparam int C_NSPC = 4;
  localparam int C_FULL = 5;
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import dispatch_pkg::*;
(
  input  slot_flags_t flags,
  output slot_kind_t  kind
);
  always_comb begin
    if (flags.sq)         kind = K_SQ;
    else if (flags.ld)    kind = K_LD;
    else if (flags.st)    kind = K_ST;
    else if (flags.nspec) kind = K_NS;
    else if (flags.nop)   kind = K_NOP;
    else if (flags.exe)   kind = K_EXE;
    else                  kind = K_NORM;
  end
endmodule

// File: rtl/dispatch_scan.sv
module dispatch_scan
  import dispatch_pkg::*;
#(
  parameter int W    = 4,
  parameter int FW   = 5,
  parameter int CNTW = 3
) (
  input  logic                        valid,
  input  logic [CNTW-1:0]             count,
  input  logic [FW-1:0]               free,
  input  slot_kind_t [W-1:0]          kinds,
  output logic [W-1:0]                iq,
  output logic [W-1:0]                lsq,
  output logic [W-1:0]                nsl,
  output logic [W-1:0]                tail,
  output logic [W-1:0]                iss,
  output logic [W-1:0]                exe,
  output logic [W-1:0]                cmt,
  output logic [W-1:0]                err,
  output logic                        full,
  output logic [NCNT-1:0][CNTW-1:0]   inc
);
  logic [FW-1:0] rem;
  logic          stop;

  always_comb begin
    rem  = free;
    stop = 1'b0;
    iq = '0; lsq = '0; nsl = '0; tail = '0;
    iss = '0; exe = '0; cmt = '0; err = '0;
    full = 1'b0;
    inc  = '0;
    for (int i = 0; i < W; i++) begin
      if (valid && (i < int'(count)) && !stop) begin
        if (kinds[i] == K_SQ) begin
          inc[C_SQSH] = inc[C_SQSH] + 1'b1;
        end else if (rem == '0) begin
          stop = 1'b1;
          full = 1'b1;
        end else begin
          case (kinds[i])
            K_LD, K_ST, K_NORM: begin
              iq[i] = 1'b1;
              rem   = rem - 1'b1;
              inc[C_DISP] = inc[C_DISP] + 1'b1;
              if (kinds[i] == K_LD) begin
                lsq[i] = 1'b1;
                inc[C_LOAD] = inc[C_LOAD] + 1'b1;
              end else if (kinds[i] == K_ST) begin
                lsq[i] = 1'b1;
                inc[C_STOR] = inc[C_STOR] + 1'b1;
              end
            end
            K_NS: begin
              nsl[i] = 1'b1;
              cmt[i] = 1'b1;
              inc[C_NSPC] = inc[C_NSPC] + 1'b1;
            end
            default: begin // nop or arrived-executed
              tail[i] = 1'b1;
              iss[i]  = 1'b1;
              exe[i]  = 1'b1;
              cmt[i]  = 1'b1;
              err[i]  = (kinds[i] == K_EXE);
            end
          endcase
        end
      end
    end
    inc[C_FULL] = CNTW'(full);
  end
endmodule

// File: rtl/dispatch_counters.sv
module dispatch_counters
  import dispatch_pkg::*;
#(
  parameter int CW   = 16,
  parameter int CNTW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCNT-1:0][CNTW-1:0] inc,
  output logic [NCNT-1:0][CW-1:0]   cnt
);
  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[k] <= '0;
      else        cnt[k] <= cnt[k] + CW'(inc[k]);
    end
  end
endmodule

// File: rtl/dispatch_classifier.sv
module dispatch_classifier
  import dispatch_pkg::*;
#(
  parameter int W  = 4,
  parameter int FW = 5,
  parameter int CW = 16,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CNTW-1:0]    in_count,
  input  logic [FLW*W-1:0]   in_flags,
  input  logic [FW-1:0]      iq_free,
  output logic [W-1:0]       iq_we,
  output logic [W-1:0]       lsq_we,
  output logic [W-1:0]       nsl_we,
  output logic [W-1:0]       tail_adv,
  output logic [W-1:0]       mark_issued,
  output logic [W-1:0]       mark_executed,
  output logic [W-1:0]       mark_commit,
  output logic [W-1:0]       exec_err,
  output logic               block_req,
  output logic [CW-1:0]      cnt_disp,
  output logic [CW-1:0]      cnt_sqsh,
  output logic [CW-1:0]      cnt_load,
  output logic [CW-1:0]      cnt_store,
  output logic [CW-1:0]      cnt_nspec,
  output logic [CW-1:0]      cnt_full
);
  slot_kind_t [W-1:0]        kinds;
  logic [W-1:0]              n_iq, n_lsq, n_nsl, n_tail, n_iss, n_exe, n_cmt, n_err;
  logic                      n_full;
  logic [NCNT-1:0][CNTW-1:0] inc;
  logic [NCNT-1:0][CW-1:0]   cnt;

  for (genvar i = 0; i < W; i++) begin : g_slot
    slot_decode u_dec (
      .flags (slot_flags_t'(in_flags[FLW*i +: FLW])),
      .kind  (kinds[i])
    );
  end

  dispatch_scan #(.W(W), .FW(FW), .CNTW(CNTW)) u_scan (
    .valid (in_valid), .count (in_count), .free (iq_free), .kinds (kinds),
    .iq (n_iq), .lsq (n_lsq), .nsl (n_nsl), .tail (n_tail),
    .iss (n_iss), .exe (n_exe), .cmt (n_cmt), .err (n_err),
    .full (n_full), .inc (inc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_we <= '0; lsq_we <= '0; nsl_we <= '0; tail_adv <= '0;
      mark_issued <= '0; mark_executed <= '0; mark_commit <= '0;
      exec_err <= '0; block_req <= 1'b0;
    end else begin
      iq_we <= n_iq; lsq_we <= n_lsq; nsl_we <= n_nsl; tail_adv <= n_tail;
      mark_issued <= n_iss; mark_executed <= n_exe; mark_commit <= n_cmt;
      exec_err <= n_err; block_req <= n_full;
    end
  end

  dispatch_counters #(.CW(CW), .CNTW(CNTW)) u_cnt (
    .clk (clk), .rst_n (rst_n), .inc (inc), .cnt (cnt)
  );

  assign cnt_disp  = cnt[C_DISP];
  assign cnt_sqsh  = cnt[C_SQSH];
  assign cnt_load  = cnt[C_LOAD];
  assign cnt_store = cnt[C_STOR];
  assign cnt_nspec = cnt[C_NSPC];
  assign cnt_full  = cnt[C_FULL];
endmodule

// File: rtl/dispatch_classifier_chk.sv
module dispatch_classifier_chk #(
  parameter int W  = 4,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  iq_we,
  input logic [W-1:0]  lsq_we,
  input logic [W-1:0]  nsl_we,
  input logic [W-1:0]  tail_adv,
  input logic [W-1:0]  exec_err,
  input logic          block_req,
  input logic [CW-1:0] cnt_disp,
  input logic [CW-1:0] cnt_full
);
  for (genvar i = 0; i < W; i++) begin : g_one
    // R5 R6 R10: one destination per slot
    assert_one_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iq_we[i], nsl_we[i], tail_adv[i]}));
  end

  // R4: memory-queue reservation always accompanied by an issue-queue insert
  assert_mem_also_iq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsq_we & ~iq_we) == '0);

  // R7: executed-on-arrival slot advances the tail like a nop
  assert_err_is_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_err & ~tail_adv) == '0);

  // R1: no group, no activity on the next cycle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (iq_we == '0 && nsl_we == '0 && tail_adv == '0 && !block_req));

  // R8: counters follow the registered strobes
  assert_disp_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_disp == $past(cnt_disp) + CW'($countones(iq_we)) || $past(!rst_n));
  assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_full == $past(cnt_full) + CW'(block_req) || $past(!rst_n));
endmodule

bind dispatch_classifier dispatch_classifier_chk #(.W(W), .CW(CW)) u_chk (
  .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
  .iq_we (iq_we), .lsq_we (lsq_we), .nsl_we (nsl_we), .tail_adv (tail_adv),
  .exec_err (exec_err), .block_req (block_req),
  .cnt_disp (cnt_disp), .cnt_full (cnt_full)
);

// File: tb/sim_dispatch_classifier.sv
`timescale 1ns/1ps
module sim_dispatch_classifier;
  localparam int W = 4, FW = 5, CW = 16, CNTW = 3;
  localparam int NV = 9;
  // {count3, flags24 (slot3..slot0), free5, iq4, lsq4, nsl4, tail4, err4, blk1, sq3}
  localparam logic [55:0] VEC [NV] = '{
    {3'd4, {6'd0, 6'd0, 6'd0, 6'd0},   5'd8, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 3'd0},
    {3'd4, {6'd16, 6'd8, 6'd4, 6'd2},  5'd8, 4'b0011, 4'b0011, 4'b0100, 4'b1000, 4'b0000, 1'b0, 3'd0},
    {3'd4, {6'd0, 6'd1, 6'd0, 6'd1},   5'd1, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 3'd2},
    {3'd2, {6'd0, 6'd0, 6'd0, 6'd0},   5'd8, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 3'd0},
    {3'd4, {6'd0, 6'd0, 6'd8, 6'd16},  5'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 3'd0},
    {3'd4, {6'd0, 6'd32, 6'd0, 6'd6},  5'd2, 4'b0011, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b1, 3'd0},
    {3'd0, {6'd0, 6'd0, 6'd0, 6'd0},   5'd8, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 3'd0},
    {3'd4, {6'd1, 6'd8, 6'd16, 6'd32}, 5'd1, 4'b0000, 4'b0000, 4'b0100, 4'b0011, 4'b0001, 1'b0, 3'd1},
    {3'd4, {6'd0, 6'd16, 6'd0, 6'd0},  5'd1, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [CNTW-1:0] in_count = '0;
  logic [6*W-1:0]  in_flags = '0;
  logic [FW-1:0]   iq_free = '0;
  logic [W-1:0] iq_we, lsq_we, nsl_we, tail_adv, mark_issued, mark_executed, mark_commit, exec_err;
  logic block_req;
  logic [CW-1:0] cnt_disp, cnt_sqsh, cnt_load, cnt_store, cnt_nspec, cnt_full;
  int errors = 0, checks = 0;
  int e_disp = 0, e_sq = 0, e_ld = 0, e_st = 0, e_ns = 0, e_full = 0;

  always #10 clk = ~clk;

  dispatch_classifier #(.W(W), .FW(FW), .CW(CW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] c, input logic [23:0] f, input logic [4:0] fr);
    @(negedge clk);
    in_valid = v; in_count = c; in_flags = f; iq_free = fr;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_counters();
    chk("R8 cnt_disp", int'(cnt_disp), e_disp);
    chk("R2 cnt_sqsh", int'(cnt_sqsh), e_sq);
    chk("R8 cnt_load", int'(cnt_load), e_ld);
    chk("R8 cnt_store", int'(cnt_store), e_st);
    chk("R5 cnt_nspec", int'(cnt_nspec), e_ns);
    chk("R3 cnt_full", int'(cnt_full), e_full);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    chk("R9 strobes", int'({iq_we, lsq_we, nsl_we, tail_adv}), 0);
    chk("R9 marks", int'({mark_issued, mark_executed, mark_commit, exec_err, block_req}), 0);
    chk_counters();

    for (int v = 0; v < NV; v++) begin
      logic [55:0] e;
      e = VEC[v];
      apply(1'b1, e[55:53], e[52:29], e[28:24]);
      chk("R10 iq_we", int'(iq_we), int'(e[23:20]));
      chk("R4 lsq_we", int'(lsq_we), int'(e[19:16]));
      chk("R5 nsl_we", int'(nsl_we), int'(e[15:12]));
      chk("R6 tail_adv", int'(tail_adv), int'(e[11:8]));
      chk("R7 exec_err", int'(exec_err), int'(e[7:4]));
      chk("R3 block_req", int'(block_req), int'(e[3]));
      e_disp += $countones(e[23:20]);
      e_ns   += $countones(e[15:12]);
      e_full += int'(e[3]);
      e_sq   += int'(e[2:0]);
      for (int s = 0; s < W; s++)
        if (e[16+s]) begin
          if (e[29 + 6*s + 1]) e_ld++; else e_st++;
        end
    end
    chk_counters();

    // R6 status marks for load/store/nspec/nop group
    apply(1'b1, 3'd4, {6'd16, 6'd8, 6'd4, 6'd2}, 5'd8);
    chk("R6 mark_issued", int'(mark_issued), 4'b1000);
    chk("R6 mark_executed", int'(mark_executed), 4'b1000);
    chk("R5 mark_commit", int'(mark_commit), 4'b1100);
    e_disp += 2; e_ld++; e_st++; e_ns++;

    // R7 arrived-executed handled as nop
    apply(1'b1, 3'd4, {6'd1, 6'd8, 6'd16, 6'd32}, 5'd1);
    chk("R7 mark_issued", int'(mark_issued), 4'b0011);
    chk("R7 mark_executed", int'(mark_executed), 4'b0011);
    chk("R7 mark_commit", int'(mark_commit), 4'b0111);
    e_ns++; e_sq++;

    // R1 invalid group ignored
    apply(1'b0, 3'd4, {6'd2, 6'd4, 6'd8, 6'd0}, 5'd8);
    chk("R1 idle strobes", int'({iq_we, lsq_we, nsl_we, tail_adv, block_req}), 0);
    chk("R1 idle marks", int'({mark_issued, mark_executed, mark_commit, exec_err}), 0);
    chk_counters();

    // R10 free count bounds insertions exactly
    apply(1'b1, 3'd4, {6'd0, 6'd0, 6'd0, 6'd0}, 5'd3);
    chk("R10 free limit", int'(iq_we), 4'b0111);
    chk("R3 free limit block", int'(block_req), 1);
    e_disp += 3; e_full++;
    chk_counters();

    // R9 reset clears counters
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk); rst_n = 1'b1;
    e_disp = 0; e_sq = 0; e_ld = 0; e_st = 0; e_ns = 0; e_full = 0;
    chk_counters();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule